// File: doc/BRIEF.md
# Flash Region Scan and Verify Engine

This engine walks a range of flash memory one 64-bit doubleword at a time and performs one of three scans on it: a blank check (every doubleword must read as all ones), a verify against a source buffer held in ordinary memory, or a 32-bit checksum. A single command carries the scan mode, the start address, the byte count and, for verify, the source buffer address. Before any read is issued, the arguments are checked for doubleword alignment and for range. The whole range must fall inside either the main array or the shadow row. The base and size of each region are inputs, held stable while a scan runs.

The engine fetches flash data and source data through two simple read ports. Each port returns data one cycle after its read enable. A scan stops at the first failing doubleword. The engine then records the failing address, the flash value and, for verify, the source value. A one-cycle done pulse marks the end of every command, and the status code is valid from that cycle onward. The failure registers change only when a new failure is found, so they still hold the last failure after later commands that pass.

Top module: `flash_scan_engine`

## Requirements
- R1: A start address or byte size whose low three bits are not zero ends the command with status 0x100. This check takes priority over the range check.
- R2: In verify mode (mode code 1), a source address whose low two bits are not zero gives status 0x100. In the other modes the source address is ignored.
- R3: The start must satisfy base <= start < base+size, and the end (start+size) must satisfy base <= end <= base+size. Both must hold for the same region, main or shadow. Otherwise the status is 0x200 and no flash read is issued.
- R4: A byte size of zero with valid arguments ends with status 0x000 and a done pulse in the cycle after the command is accepted, and the sum reads zero.
- R5: Blank check (mode code 0) stops at the first doubleword that is not all ones, with status 0x600. It records that address in fail_addr and its data in fail_data. Later non-blank doublewords are not reported.
- R6: Verify (mode code 1) compares doubleword k of flash with the 64 bits at source address + 8k, where the lower word sits at the lower address. On the first mismatch it gives status 0x700 and records the address, the flash value and the source value.
- R7: Checksum (mode code 2) adds the low and then the high 32-bit half of every doubleword, discarding carries. It ends with status 0x000, and the result is then on sum.
- R8: fail_addr, fail_data and fail_src keep their values through any command that finds no failure. A blank-check failure leaves fail_src unchanged.
- R9: done is high for exactly one cycle per command, and busy is low in that cycle. A command presented while busy is high is ignored.
- R10: Flash reads go out in ascending address order, one doubleword every two cycles, and never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_mode | input | 2 | 0 blank check, 1 verify, 2 checksum |
| cmd_addr | input | AW | Flash start address |
| cmd_size | input | AW | Byte count |
| cmd_src | input | AW | Source buffer address (verify) |
| main_base | input | AW | Main array base address |
| main_size | input | AW | Main array size in bytes |
| shad_base | input | AW | Shadow row base address |
| shad_size | input | AW | Shadow row size in bytes |
| fl_rd_en | output | 1 | Flash read enable |
| fl_rd_addr | output | AW | Flash read address |
| fl_rd_data | input | 64 | Flash data, one cycle after enable |
| src_rd_en | output | 1 | Source read enable |
| src_rd_addr | output | AW | Source read address |
| src_rd_data | input | 64 | Source data, one cycle after enable |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| status | output | 12 | Result code of the last command |
| fail_addr | output | AW | First failing flash address |
| fail_data | output | 64 | Flash value at the failure |
| fail_src | output | 64 | Source value at the failure |
| sum | output | 32 | Checksum result |

## Verification
A wrong address or count register inside the sequencer shows up within one scan, as a wrong fail_addr or as a status that does not match the chosen range. A faulty compare or wrong mode decode appears at done as the wrong status, or as a stop on an earlier or later doubleword than the first real failure. A capture enable that fires when it should not overwrites the failure registers during a passing scan, and this is visible on the next command. An error in the argument checker appears in the very next cycle as a wrong status, or as a read pulse that should never have been issued.

// File: rtl/fse_pkg.sv
package fse_pkg;
  typedef enum logic [1:0] {
    MODE_BLANK  = 2'd0,
    MODE_VERIFY = 2'd1,
    MODE_SUM    = 2'd2,
    MODE_SUM2   = 2'd3
  } scan_mode_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_READ = 2'd1,
    S_EVAL = 2'd2
  } seq_state_e;

  localparam int unsigned DWW = 64;
  localparam int unsigned HWW = 32;
  localparam int unsigned STW = 12;

  localparam logic [STW-1:0] ST_OK        = 12'h000;
  localparam logic [STW-1:0] ST_ALIGN     = 12'h100;
  localparam logic [STW-1:0] ST_RANGE     = 12'h200;
  localparam logic [STW-1:0] ST_NOT_BLANK = 12'h600;
  localparam logic [STW-1:0] ST_MISMATCH  = 12'h700;
endpackage

// File: rtl/fse_arg_check.sv
module fse_arg_check
  import fse_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [1:0]     mode,
  input  logic [AW-1:0]  addr,
  input  logic [AW-1:0]  size,
  input  logic [AW-1:0]  src,
  input  logic [AW-1:0]  main_base,
  input  logic [AW-1:0]  main_size,
  input  logic [AW-1:0]  shad_base,
  input  logic [AW-1:0]  shad_size,
  output logic           arg_err,
  output logic [STW-1:0] err_code
);
  localparam int unsigned XW = AW + 1;

  logic [XW-1:0] end_x, main_lim, shad_lim, addr_x, mb_x, sb_x;
  logic          in_main, in_shad, mis_dw, mis_src;

  always_comb begin
    addr_x   = {1'b0, addr};
    mb_x     = {1'b0, main_base};
    sb_x     = {1'b0, shad_base};
    end_x    = addr_x + {1'b0, size};
    main_lim = mb_x + {1'b0, main_size};
    shad_lim = sb_x + {1'b0, shad_size};
    in_main  = (addr_x >= mb_x) && (addr_x < main_lim) &&
               (end_x >= mb_x) && (end_x <= main_lim);
    in_shad  = (addr_x >= sb_x) && (addr_x < shad_lim) &&
               (end_x >= sb_x) && (end_x <= shad_lim);
    mis_dw   = (addr[2:0] != 3'd0) || (size[2:0] != 3'd0);
    mis_src  = (mode == MODE_VERIFY) && (src[1:0] != 2'd0);
    if (mis_dw || mis_src) begin
      err_code = ST_ALIGN;
    end else if (!(in_main || in_shad)) begin
      err_code = ST_RANGE;
    end else begin
      err_code = ST_OK;
    end
    arg_err = (err_code != ST_OK);
  end
endmodule

// File: rtl/fse_seq.sv
module fse_seq
  import fse_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_mode,
  input  logic [AW-1:0] cmd_addr,
  input  logic [AW-1:0] cmd_size,
  input  logic [AW-1:0] cmd_src,
  input  logic          arg_err,
  input  logic          stop,
  output logic          accept,
  output logic          eval,
  output logic          finish,
  output logic          busy,
  output logic          done,
  output logic [1:0]    mode_q,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_src,
  output logic          fl_rd_en,
  output logic          src_rd_en
);
  localparam logic [AW-1:0] STEP = AW'(8);
  localparam logic [AW-1:0] ONE  = AW'(1);

  seq_state_e    st_q, st_d;
  logic [AW-1:0] addr_d, src_d, left_q, left_d;
  logic [1:0]    mode_d;
  logic          zero_sz;

  always_comb begin
    st_d    = st_q;
    addr_d  = cur_addr;
    src_d   = cur_src;
    left_d  = left_q;
    mode_d  = mode_q;
    finish  = 1'b0;
    accept  = (st_q == S_IDLE) && cmd_valid;
    eval    = (st_q == S_EVAL);
    zero_sz = (cmd_size == '0);
    unique case (st_q)
      S_IDLE: if (accept) begin
        mode_d = cmd_mode;
        if (arg_err || zero_sz) begin
          finish = 1'b1;
        end else begin
          st_d   = S_READ;
          addr_d = cmd_addr;
          src_d  = cmd_src;
          left_d = cmd_size >> 3;
        end
      end
      S_READ: st_d = S_EVAL;
      S_EVAL: begin
        if (stop || (left_q == ONE)) begin
          finish = 1'b1;
          st_d   = S_IDLE;
        end else begin
          st_d   = S_READ;
          addr_d = cur_addr + STEP;
          src_d  = cur_src + STEP;
          left_d = left_q - ONE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      cur_addr <= '0;
      cur_src  <= '0;
      left_q   <= '0;
      mode_q   <= '0;
      done     <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_addr <= addr_d;
      cur_src  <= src_d;
      left_q   <= left_d;
      mode_q   <= mode_d;
      done     <= finish;
    end
  end

  assign busy      = (st_q != S_IDLE);
  assign fl_rd_en  = (st_q == S_READ);
  assign src_rd_en = (st_q == S_READ) && (mode_q == MODE_VERIFY);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  a_r10_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd_en |=> !fl_rd_en);
  a_r3_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && arg_err) |=> (!busy && done));
  a_r4_zero_done: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !arg_err && (cmd_size == '0)) |=> done);
  a_r10_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !finish) |=> (cur_addr == $past(cur_addr) + STEP));
endmodule

// File: rtl/fse_result.sv
module fse_result
  import fse_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           accept,
  input  logic           eval,
  input  logic           finish,
  input  logic [1:0]     mode_q,
  input  logic [STW-1:0] err_code,
  input  logic [AW-1:0]  cur_addr,
  input  logic [DWW-1:0] fl_data,
  input  logic [DWW-1:0] src_data,
  output logic           stop,
  output logic [STW-1:0] status,
  output logic [AW-1:0]  fail_addr,
  output logic [DWW-1:0] fail_data,
  output logic [DWW-1:0] fail_src,
  output logic [HWW-1:0] sum
);
  logic [HWW-1:0] sum_d, part;
  logic [STW-1:0] st_d;
  logic           blank_bad, cmp_bad, cap_en, cap_src_en;

  always_comb begin
    blank_bad  = (mode_q == MODE_BLANK) && (fl_data != {DWW{1'b1}});
    cmp_bad    = (mode_q == MODE_VERIFY) && (fl_data != src_data);
    stop       = eval && (blank_bad || cmp_bad);
    cap_en     = stop;
    cap_src_en = eval && cmp_bad;
    part       = sum + fl_data[HWW-1:0];
    sum_d      = sum;
    if (accept) begin
      sum_d = '0;
    end else if (eval && mode_q[1]) begin
      sum_d = part + fl_data[DWW-1:HWW];
    end
    if (!eval) begin
      st_d = err_code;
    end else if (blank_bad) begin
      st_d = ST_NOT_BLANK;
    end else if (cmp_bad) begin
      st_d = ST_MISMATCH;
    end else begin
      st_d = ST_OK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status    <= ST_OK;
      sum       <= '0;
      fail_addr <= '0;
      fail_data <= '0;
      fail_src  <= '0;
    end else begin
      if (finish) status <= st_d;
      sum <= sum_d;
      if (cap_en) begin
        fail_addr <= cur_addr;
        fail_data <= fl_data;
      end
      if (cap_src_en) fail_src <= src_data;
    end
  end

  a_r8_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !eval |=> ($stable(fail_addr) && $stable(fail_data) && $stable(fail_src)));
  a_r8_src_hold_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_BLANK) |=> $stable(fail_src));
  a_r7_sum_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && !mode_q[1]) |=> $stable(sum));
endmodule

// File: rtl/flash_scan_engine.sv
module flash_scan_engine
  import fse_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  input  logic [1:0]     cmd_mode,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [AW-1:0]  cmd_size,
  input  logic [AW-1:0]  cmd_src,
  input  logic [AW-1:0]  main_base,
  input  logic [AW-1:0]  main_size,
  input  logic [AW-1:0]  shad_base,
  input  logic [AW-1:0]  shad_size,
  output logic           fl_rd_en,
  output logic [AW-1:0]  fl_rd_addr,
  input  logic [63:0]    fl_rd_data,
  output logic           src_rd_en,
  output logic [AW-1:0]  src_rd_addr,
  input  logic [63:0]    src_rd_data,
  output logic           busy,
  output logic           done,
  output logic [11:0]    status,
  output logic [AW-1:0]  fail_addr,
  output logic [63:0]    fail_data,
  output logic [63:0]    fail_src,
  output logic [31:0]    sum
);
  logic           arg_err, accept, eval, finish, stop;
  logic [STW-1:0] err_code;
  logic [1:0]     mode_q;

  fse_arg_check #(.AW(AW)) u_chk (
    .mode(cmd_mode), .addr(cmd_addr), .size(cmd_size), .src(cmd_src),
    .main_base(main_base), .main_size(main_size),
    .shad_base(shad_base), .shad_size(shad_size),
    .arg_err(arg_err), .err_code(err_code)
  );

  fse_seq #(.AW(AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_src(cmd_src),
    .arg_err(arg_err), .stop(stop), .accept(accept), .eval(eval),
    .finish(finish), .busy(busy), .done(done), .mode_q(mode_q),
    .cur_addr(fl_rd_addr), .cur_src(src_rd_addr),
    .fl_rd_en(fl_rd_en), .src_rd_en(src_rd_en)
  );

  fse_result #(.AW(AW)) u_res (
    .clk(clk), .rst_n(rst_n), .accept(accept), .eval(eval), .finish(finish),
    .mode_q(mode_q), .err_code(err_code), .cur_addr(fl_rd_addr),
    .fl_data(fl_rd_data), .src_data(src_rd_data), .stop(stop),
    .status(status), .fail_addr(fail_addr), .fail_data(fail_data),
    .fail_src(fail_src), .sum(sum)
  );

  a_r5_stop_only_scan: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> busy);
endmodule

// File: tb/test_flash_scan_engine.sv
`timescale 1ns/1ps
module test_flash_scan_engine;
  localparam int AW = 32;
  localparam logic [31:0] MB = 32'h1000, MS = 32'h200;
  localparam logic [31:0] SB = 32'h4000, SS = 32'h40;
  localparam logic [31:0] XB = 32'h8000;

  typedef struct packed {
    logic [1:0]  m;
    logic [31:0] a;
    logic [31:0] s;
    logic [31:0] src;
    logic [11:0] st;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 32'h1000, 32'h80,   32'h0,    12'h000},
    '{2'd0, 32'h1000, 32'h100,  32'h0,    12'h600},
    '{2'd1, 32'h1100, 32'h80,   32'h8000, 12'h000},
    '{2'd1, 32'h1100, 32'h100,  32'h8000, 12'h700},
    '{2'd2, 32'h1100, 32'h40,   32'h0,    12'h000},
    '{2'd0, 32'h1004, 32'h8,    32'h0,    12'h100},
    '{2'd2, 32'h1000, 32'h0C,   32'h0,    12'h100},
    '{2'd1, 32'h1100, 32'h8,    32'h8002, 12'h100},
    '{2'd0, 32'h1000, 32'h8,    32'h8002, 12'h000},
    '{2'd2, 32'h11F8, 32'h10,   32'h0,    12'h200},
    '{2'd0, 32'h0800, 32'h8,    32'h0,    12'h200},
    '{2'd0, 32'h1000, 32'h3000, 32'h0,    12'h200},
    '{2'd2, 32'h1000, 32'h0,    32'h0,    12'h000},
    '{2'd0, 32'h1003, 32'h0,    32'h0,    12'h100},
    '{2'd0, 32'h4000, 32'h40,   32'h0,    12'h600},
    '{2'd2, 32'h11F8, 32'h8,    32'h0,    12'h000},
    '{2'd0, 32'h0804, 32'h8,    32'h0,    12'h100},
    '{2'd1, 32'h1100, 32'h8,    32'h8004, 12'h700},
    '{2'd2, 32'h4000, 32'h40,   32'h0,    12'h000},
    '{2'd2, 32'h1200, 32'h0,    32'h0,    12'h200}
  };

  logic        clk, rst_n, cmd_valid;
  logic [1:0]  cmd_mode;
  logic [31:0] cmd_addr, cmd_size, cmd_src;
  logic        fl_rd_en, src_rd_en, busy, done;
  logic [31:0] fl_rd_addr, src_rd_addr, fail_addr, sum;
  logic [63:0] fl_rd_data, src_rd_data, fail_data, fail_src;
  logic [11:0] status;

  logic [63:0] fmem [64];
  logic [63:0] smem [8];
  logic [31:0] swrd [128];

  int errors = 0, checks = 0;
  logic [31:0] exp_faddr = '0;
  logic [63:0] exp_fdata = '0, exp_fsrc = '0;

  flash_scan_engine #(.AW(AW)) i_flash_scan_engine (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_mode(cmd_mode),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .cmd_src(cmd_src),
    .main_base(MB), .main_size(MS), .shad_base(SB), .shad_size(SS),
    .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
    .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
    .busy(busy), .done(done), .status(status), .fail_addr(fail_addr),
    .fail_data(fail_data), .fail_src(fail_src), .sum(sum)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [63:0] fl_model(input logic [31:0] a);
    if (a >= MB && a < MB + MS) return fmem[(a - MB) >> 3];
    if (a >= SB && a < SB + SS) return smem[(a - SB) >> 3];
    return 64'h0;
  endfunction

  function automatic logic [63:0] src_model(input logic [31:0] a);
    int i;
    i = int'((a - XB) >> 2);
    if (a < XB || i > 126) return 64'h0;
    return {swrd[i+1], swrd[i]};
  endfunction

  always @(posedge clk) begin
    if (fl_rd_en) fl_rd_data <= fl_model(fl_rd_addr);
    if (src_rd_en) src_rd_data <= src_model(src_rd_addr);
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic wait_done(output bit ok);
    int cyc = 0;
    ok = 1'b1;
    while (!done && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      ok = 1'b0;
      chk("R9 watchdog done", 64'd0, 64'd1);
    end
  endtask

  task automatic run_cmd(input logic [1:0] m, input logic [31:0] a, s, src);
    bit ok;
    cmd_mode = m; cmd_addr = a; cmd_size = s; cmd_src = src;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    wait_done(ok);
    if (ok) chk("R9 busy low at done", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk("R9 global watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++)
      fmem[i] = (i < 32) ? {64{1'b1}}
              : {32'hC0DE0000 + 32'(i), 32'h5A000000 ^ (32'(i) * 32'h01010101)};
    fmem[20] = 64'hFFFF_FFFF_FFFF_FFFE;
    fmem[25] = 64'h0;
    for (int i = 0; i < 8; i++) smem[i] = {64{1'b1}};
    smem[5] = 64'h0123_FFFF_FFFF_FFFF;
    for (int i = 0; i < 128; i++) swrd[i] = 32'h0;
    for (int j = 0; j < 32; j++) begin
      swrd[2*j]   = fmem[32+j][31:0];
      swrd[2*j+1] = fmem[32+j][63:32];
    end
    swrd[41] = swrd[41] ^ 32'h1;

    cmd_valid = 1'b0; cmd_mode = '0; cmd_addr = '0; cmd_size = '0; cmd_src = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R9 reset done", 64'(done), 64'd0);
    chk("R9 reset busy", 64'(busy), 64'd0);
    chk("R8 reset status", 64'(status), 64'd0);
    chk("R8 reset fail_addr", 64'(fail_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      logic        miss;
      logic [31:0] fa, acc;
      logic [63:0] fd, fs;
      miss = 1'b0; fa = '0; fd = '0; fs = '0; acc = '0;
      for (int k = 0; k < int'(VECS[v].s >> 3); k++) begin
        logic [31:0] ad;
        logic [63:0] d, sd;
        ad = VECS[v].a + 32'(8 * k);
        d  = fl_model(ad);
        sd = src_model(VECS[v].src + 32'(8 * k));
        if (!miss) begin
          acc = acc + d[31:0] + d[63:32];
          if ((VECS[v].m == 2'd0 && d != {64{1'b1}}) || (VECS[v].m == 2'd1 && d != sd)) begin
            miss = 1'b1; fa = ad; fd = d; fs = sd;
          end
        end
      end
      run_cmd(VECS[v].m, VECS[v].a, VECS[v].s, VECS[v].src);
      if (VECS[v].st == 12'h600) begin exp_faddr = fa; exp_fdata = fd; end
      if (VECS[v].st == 12'h700) begin exp_faddr = fa; exp_fdata = fd; exp_fsrc = fs; end
      case (VECS[v].st)
        12'h100: chk($sformatf("R1 R2 align status v%0d", v), 64'(status), 64'h100);
        12'h200: chk($sformatf("R3 range status v%0d", v), 64'(status), 64'h200);
        12'h600: chk($sformatf("R5 blank status v%0d", v), 64'(status), 64'h600);
        12'h700: chk($sformatf("R6 verify status v%0d", v), 64'(status), 64'h700);
        default: chk($sformatf("R4 R7 ok status v%0d", v), 64'(status), 64'h000);
      endcase
      chk($sformatf("R5 R6 R8 fail_addr v%0d", v), 64'(fail_addr), 64'(exp_faddr));
      chk($sformatf("R5 R6 R8 fail_data v%0d", v), fail_data, exp_fdata);
      chk($sformatf("R6 R8 fail_src v%0d", v), fail_src, exp_fsrc);
      if (VECS[v].m == 2'd2 && VECS[v].st == 12'h000)
        chk($sformatf("R7 sum v%0d", v), 64'(sum), 64'(acc));
      @(negedge clk);
      chk($sformatf("R9 done one cycle v%0d", v), 64'(done), 64'd0);
    end

    // R4: zero size finishes in the cycle after acceptance
    cmd_mode = 2'd0; cmd_addr = 32'h4000; cmd_size = 32'h0; cmd_src = '0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R4 done next cycle", 64'(done), 64'd1);
    chk("R4 status ok", 64'(status), 64'h000);
    @(negedge clk);

    // R10: reads spaced by two cycles and ascending
    begin
      logic [31:0] prev;
      int nrd;
      bit  adj;
      prev = '0; nrd = 0; adj = 1'b0;
      cmd_mode = 2'd2; cmd_addr = 32'h1100; cmd_size = 32'h20;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!done && nrd < 200) begin
        if (fl_rd_en) begin
          if (nrd > 0) chk("R10 ascending address", 64'(fl_rd_addr), 64'(prev + 32'h8));
          prev = fl_rd_addr;
          @(negedge clk);
          if (fl_rd_en) adj = 1'b1;
        end else begin
          @(negedge clk);
        end
        nrd++;
      end
      chk("R10 no back-to-back reads", 64'(adj), 64'd0);
      chk("R10 last read address", 64'(prev), 64'h1118);
      @(negedge clk);
    end

    // R9: a command while busy is ignored
    cmd_mode = 2'd2; cmd_addr = 32'h1100; cmd_size = 32'h40; cmd_src = '0;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    cmd_mode = 2'd0; cmd_addr = 32'h1004; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      bit ok;
      logic [31:0] acc;
      acc = '0;
      for (int k = 0; k < 8; k++)
        acc = acc + fmem[32+k][31:0] + fmem[32+k][63:32];
      wait_done(ok);
      chk("R9 busy command ignored status", 64'(status), 64'h000);
      chk("R9 busy command ignored sum", 64'(sum), 64'(acc));
      chk("R8 fail_addr held", 64'(fail_addr), 64'(exp_faddr));
    end
    @(negedge clk);
    chk("R9 no second done", 64'(done), 64'd0);

    finish_run();
  end
endmodule